// File: doc/BRIEF.md
# Transmit Descriptor Ring DMA Engine

This engine moves transmit frames from memory to a MAC byte-stream input. Software builds a ring of 16-byte descriptors at a 16-byte aligned base address. Each descriptor holds a flag word, a byte-count word, a buffer address low word and a buffer address high word. After filling one or more entries, software writes a pointer register so that it points one descriptor past the newest entry. The engine walks the ring from its current position until that position equals the pointer. For each descriptor it fetches three words through a single-outstanding memory read port, then reads the buffer word by word and streams its bytes. A descriptor flagged end-of-table sends the engine back to the ring base.

A control register enables the engine and can suspend it. It also stores a parity-disable bit and a burst-length field. A status register reports one of four engine states together with the current descriptor position. Completing a descriptor that requests an interrupt sets a sticky status bit, and that bit drives an interrupt output through a mask.

Top module: `tx_ring_dma`

## Requirements
- R1: While reset is asserted and right after it is released, `tx_valid`, `mem_req` and `irq` are low, and the control and status registers read 0.
- R2: Descriptor fields are fetched with word reads at the descriptor address plus 0, 4 and 8. Word 0 bit 31 is start-of-frame, bit 30 end-of-frame, bit 29 interrupt-on-completion and bit 28 end-of-table. Word 1 bits 12:0 hold the byte count. Word 2 holds the buffer address, whose low 2 bits are ignored. The high word is never read. `mem_req` and `mem_addr` hold steady until `mem_gnt`, and read data is taken on the cycle `mem_rvalid` is high.
- R3: Buffer bytes leave in address order, least significant byte of each word first, one per cycle in which both `tx_valid` and `tx_ready` are high. `tx_valid`, `tx_data`, `tx_sof` and `tx_eof` are held while `tx_ready` is low. `tx_sof` marks the first byte of a descriptor with start-of-frame, and `tx_eof` marks the last byte of a descriptor with end-of-frame.
- R4: The engine fetches the next descriptor only while its current position differs from the pointer register. It then rests idle, and writing a new pointer restarts it, so one post may cover several descriptors.
- R5: After a descriptor with end-of-table, the current position becomes the ring base. Otherwise it advances by 16.
- R6: The ring base low register (offset 2) and the pointer register (offset 1) read back with bits 3:0 forced to zero. The base high register (offset 3) stores all 32 bits.
- R7: The status register (offset 4) reads the state in bits 1:0 (0 disabled, 1 active, 2 idle, 3 stopped) and the current descriptor position in bits 31:4.
- R8: Control bit 1 (suspend) lets the descriptor in progress finish, after which the engine stays idle even with work pending. Clearing the bit resumes the walk.
- R9: Clearing control bit 0 (enable) leaves the state active until the descriptor in flight is complete, and then the state becomes disabled. Setting enable again restarts at the ring base.
- R10: Completing a descriptor with interrupt-on-completion set raises bit 0 of the interrupt status register (offset 5). Writing 1 to that bit clears it, and a completion in the same cycle wins. `irq` equals that bit ANDed with bit 0 of the mask register (offset 6).
- R11: A descriptor with a byte count of zero completes after its three descriptor reads, with no buffer read and no byte output.
- R12: A descriptor whose start-of-frame flag is clear when no frame is open, or set while one is open, sends the engine to stopped without any byte output. Only clearing enable leaves stopped.
- R13: Control bits 20:18 (burst length) and bit 11 (parity disable) read back as written. The parity-disable bit reads back only when parity support is configured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read byte address, word aligned |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Byte valid towards the MAC |
| tx_ready | input | 1 | MAC accepts the byte |
| tx_data | output | 8 | Frame byte |
| tx_sof | output | 1 | First byte of a frame |
| tx_eof | output | 1 | Last byte of a frame |
| irq | output | 1 | Masked transmit interrupt |

## Verification
The hardest cases to reach depend on the engine being caught mid-descriptor while a control change arrives: a suspend or a disable written while bytes are still owed. The bench holds `tx_ready` low to freeze the engine in its byte phase. It waits until `tx_valid` shows, writes the control change, reads the status register during the stall, and then releases the stream. A frame that spans two descriptors and a descriptor with no start flag are posted directly into the ring to drive the open-frame tracking both ways.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int REG_AW     = 3;
  localparam int REG_DW     = 32;
  localparam int ALIGN      = 4;
  localparam int DESC_BYTES = 16;

  localparam logic [REG_AW-1:0] RA_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] RA_LAST = 3'd1;
  localparam logic [REG_AW-1:0] RA_BLO  = 3'd2;
  localparam logic [REG_AW-1:0] RA_BHI  = 3'd3;
  localparam logic [REG_AW-1:0] RA_STAT = 3'd4;
  localparam logic [REG_AW-1:0] RA_INT  = 3'd5;
  localparam logic [REG_AW-1:0] RA_MASK = 3'd6;

  localparam int CB_EN   = 0;
  localparam int CB_SUSP = 1;
  localparam int CB_PD   = 11;
  localparam int CB_BL   = 18;
  localparam int BL_W    = 3;

  // flag nibble taken from descriptor word 0 bits 31:28
  localparam int F_SOF = 3;
  localparam int F_EOF = 2;
  localparam int F_IOC = 1;
  localparam int F_EOT = 0;

  localparam logic [1:0] ST_OFF  = 2'd0;
  localparam logic [1:0] ST_ACT  = 2'd1;
  localparam logic [1:0] ST_IDLE = 2'd2;
  localparam logic [1:0] ST_STOP = 2'd3;

  typedef enum logic [2:0] {
    E_OFF, E_IDLE, E_RDREQ, E_RDWAIT, E_EMIT, E_DONE, E_STOP
  } eng_t;
endpackage

// File: rtl/txr_regs.sv
module txr_regs
  import txr_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PARITY_OK = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic [1:0]        st_code,
  input  logic [ADDR_W-1:0] cur_ptr,
  input  logic              done_ioc,
  output logic              enable,
  output logic              suspend,
  output logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] last_ptr,
  output logic              irq
);
  logic              en_q, en_d, sus_q, sus_d, pd_q, pd_d, pd_rd;
  logic [BL_W-1:0]   bl_q, bl_d;
  logic [ADDR_W-ALIGN-1:0] blo_q, blo_d, last_q, last_d;
  logic [REG_DW-1:0] bhi_q, bhi_d;
  logic              int_q, int_d, mask_q, mask_d;

  generate
    if (PARITY_OK != 0) begin : g_par
      assign pd_rd = pd_q;
    end else begin : g_nopar
      assign pd_rd = 1'b0;
    end
  endgenerate

  always_comb begin
    en_d = en_q; sus_d = sus_q; pd_d = pd_q; bl_d = bl_q;
    blo_d = blo_q; bhi_d = bhi_q; last_d = last_q; mask_d = mask_q;
    int_d = int_q;
    if (reg_wr) begin
      case (reg_addr)
        RA_CTRL: begin
          en_d  = reg_wdata[CB_EN];
          sus_d = reg_wdata[CB_SUSP];
          pd_d  = reg_wdata[CB_PD];
          bl_d  = reg_wdata[CB_BL +: BL_W];
        end
        RA_LAST: last_d = reg_wdata[ADDR_W-1:ALIGN];
        RA_BLO:  blo_d  = reg_wdata[ADDR_W-1:ALIGN];
        RA_BHI:  bhi_d  = reg_wdata;
        RA_INT:  if (reg_wdata[0]) int_d = 1'b0;
        RA_MASK: mask_d = reg_wdata[0];
        default: ;
      endcase
    end
    if (done_ioc) int_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; sus_q <= 1'b0; pd_q <= 1'b0; bl_q <= '0;
      blo_q <= '0; bhi_q <= '0; last_q <= '0; int_q <= 1'b0; mask_q <= 1'b0;
    end else begin
      en_q <= en_d; sus_q <= sus_d; pd_q <= pd_d; bl_q <= bl_d;
      blo_q <= blo_d; bhi_q <= bhi_d; last_q <= last_d;
      int_q <= int_d; mask_q <= mask_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL: begin
        reg_rdata[CB_EN]        = en_q;
        reg_rdata[CB_SUSP]      = sus_q;
        reg_rdata[CB_PD]        = pd_rd;
        reg_rdata[CB_BL +: BL_W] = bl_q;
      end
      RA_LAST: reg_rdata = REG_DW'({last_q, {ALIGN{1'b0}}});
      RA_BLO:  reg_rdata = REG_DW'({blo_q, {ALIGN{1'b0}}});
      RA_BHI:  reg_rdata = bhi_q;
      RA_STAT: reg_rdata = REG_DW'({cur_ptr[ADDR_W-1:ALIGN], 2'b00, st_code});
      RA_INT:  reg_rdata[0] = int_q;
      RA_MASK: reg_rdata[0] = mask_q;
      default: ;
    endcase
  end

  assign enable   = en_q;
  assign suspend  = sus_q;
  assign base     = {blo_q, {ALIGN{1'b0}}};
  assign last_ptr = {last_q, {ALIGN{1'b0}}};
  assign irq      = int_q & mask_q;

  // R10: a one written to the status bit clears it unless a completion lands
  assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == RA_INT && reg_wdata[0] && !done_ioc) |=> !int_q);
  // R10: a completion with interrupt request always leaves the bit set
  assert_irq_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_ioc |=> int_q);
endmodule

// File: rtl/txr_engine.sv
module txr_engine
  import txr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              suspend,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] last_ptr,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_sof,
  output logic              tx_eof,
  output logic [1:0]        st_code,
  output logic [ADDR_W-1:0] cur_ptr,
  output logic              done_ioc
);
  localparam int BYTES  = DATA_W / 8;
  localparam int LANE_W = $clog2(BYTES);
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(BYTES - 1);

  eng_t              st_q, st_d;
  logic [ADDR_W-1:0] cur_q, cur_d, buf_q, buf_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic [3:0]        flg_q, flg_d;
  logic [DATA_W-1:0] wbuf_q, wbuf_d;
  logic [LANE_W-1:0] bidx_q, bidx_d;
  logic [1:0]        widx_q, widx_d;
  logic              indesc_q, indesc_d, first_q, first_d, open_q, open_d;

  always_comb begin
    st_d = st_q; cur_d = cur_q; buf_d = buf_q; rem_d = rem_q; flg_d = flg_q;
    wbuf_d = wbuf_q; bidx_d = bidx_q; widx_d = widx_q; indesc_d = indesc_q;
    first_d = first_q; open_d = open_q; done_ioc = 1'b0;
    case (st_q)
      E_OFF: begin
        open_d = 1'b0;
        if (enable) begin st_d = E_IDLE; cur_d = base; end
      end
      E_IDLE: begin
        if (!enable) st_d = E_OFF;
        else if (!suspend && cur_q != last_ptr) begin
          st_d = E_RDREQ; indesc_d = 1'b1; widx_d = 2'd0;
        end
      end
      E_RDREQ: if (mem_gnt) st_d = E_RDWAIT;
      E_RDWAIT: begin
        if (mem_rvalid) begin
          if (indesc_q) begin
            case (widx_q)
              2'd0:    flg_d = mem_rdata[DATA_W-1 -: 4];
              2'd1:    rem_d = mem_rdata[CNT_W-1:0];
              default: buf_d = {mem_rdata[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
            endcase
            if (widx_q == 2'd2) begin
              if (flg_q[F_SOF] == open_q) st_d = E_STOP;
              else if (rem_q == '0) st_d = E_DONE;
              else begin st_d = E_RDREQ; indesc_d = 1'b0; first_d = 1'b1; end
            end else begin
              widx_d = widx_q + 2'd1; st_d = E_RDREQ;
            end
          end else begin
            wbuf_d = mem_rdata; bidx_d = '0; st_d = E_EMIT;
          end
        end
      end
      E_EMIT: begin
        if (tx_ready) begin
          rem_d = rem_q - CNT_W'(1); first_d = 1'b0; bidx_d = bidx_q + LANE_W'(1);
          if (rem_q == CNT_W'(1)) st_d = E_DONE;
          else if (bidx_q == LAST_LANE) begin
            buf_d = buf_q + ADDR_W'(BYTES); st_d = E_RDREQ;
          end
        end
      end
      E_DONE: begin
        done_ioc = flg_q[F_IOC];
        cur_d    = flg_q[F_EOT] ? base : cur_q + ADDR_W'(DESC_BYTES);
        open_d   = !flg_q[F_EOF];
        st_d     = enable ? E_IDLE : E_OFF;
      end
      E_STOP: if (!enable) st_d = E_OFF;
      default: st_d = E_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= E_OFF; cur_q <= '0; buf_q <= '0; rem_q <= '0; flg_q <= '0;
      wbuf_q <= '0; bidx_q <= '0; widx_q <= '0; indesc_q <= 1'b0;
      first_q <= 1'b0; open_q <= 1'b0;
    end else begin
      st_q <= st_d; cur_q <= cur_d; buf_q <= buf_d; rem_q <= rem_d; flg_q <= flg_d;
      wbuf_q <= wbuf_d; bidx_q <= bidx_d; widx_q <= widx_d; indesc_q <= indesc_d;
      first_q <= first_d; open_q <= open_d;
    end
  end

  assign mem_req  = (st_q == E_RDREQ);
  assign mem_addr = indesc_q ? cur_q + ADDR_W'({widx_q, 2'b00}) : buf_q;
  assign tx_valid = (st_q == E_EMIT);
  assign tx_data  = wbuf_q[{bidx_q, 3'b000} +: 8];
  assign tx_sof   = tx_valid && flg_q[F_SOF] && first_q;
  assign tx_eof   = tx_valid && flg_q[F_EOF] && (rem_q == CNT_W'(1));
  assign cur_ptr  = cur_q;

  always_comb begin
    case (st_q)
      E_OFF:   st_code = ST_OFF;
      E_IDLE:  st_code = ST_IDLE;
      E_STOP:  st_code = ST_STOP;
      default: st_code = ST_ACT;
    endcase
  end

  // R3: an offered byte and its markers stay put until accepted
  assert_hold_stream_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_sof) && $stable(tx_eof)));
  // R2: a read request keeps its address until granted
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));
  // R5: an end-of-table completion returns the position to the base
  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == E_DONE && flg_q[F_EOT]) |=> (cur_q == $past(base)));
  // R12: stopped holds while enable stays set
  assert_stop_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == E_STOP && enable) |=> (st_code == ST_STOP));
endmodule

// File: rtl/tx_ring_dma.sv
module tx_ring_dma
  import txr_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 13,
  parameter int PARITY_OK = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_sof,
  output logic              tx_eof,
  output logic              irq
);
  logic rs_q1, rs_q2;
  logic enable, suspend, done_ioc;
  logic [1:0] st_code;
  logic [ADDR_W-1:0] base, last_ptr, cur_ptr;

  // assert asynchronously, release on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin rs_q1 <= 1'b0; rs_q2 <= 1'b0; end
    else begin rs_q1 <= 1'b1; rs_q2 <= rs_q1; end
  end

  txr_regs #(.ADDR_W(ADDR_W), .PARITY_OK(PARITY_OK)) u_regs (
    .clk(clk), .rst_n(rs_q2), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .st_code(st_code),
    .cur_ptr(cur_ptr), .done_ioc(done_ioc), .enable(enable), .suspend(suspend),
    .base(base), .last_ptr(last_ptr), .irq(irq)
  );

  txr_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst_n(rs_q2), .enable(enable), .suspend(suspend), .base(base),
    .last_ptr(last_ptr), .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_sof(tx_sof), .tx_eof(tx_eof),
    .st_code(st_code), .cur_ptr(cur_ptr), .done_ioc(done_ioc)
  );
endmodule

// File: tb/tb_tx_ring_dma.sv
`timescale 1ns/1ps
module tb_tx_ring_dma;
  localparam logic [31:0] BASE = 32'h100;
  localparam logic [31:0] BUFB = 32'h400;
  // vector: {len[7:0], ioc, ready_mode[1:0], gnt_mode}
  localparam logic [11:0] VEC [6] = '{
    {8'd1,  1'b1, 2'd0, 1'b0}, {8'd4,  1'b1, 2'd1, 1'b0},
    {8'd5,  1'b0, 2'd0, 1'b1}, {8'd13, 1'b1, 2'd1, 1'b1},
    {8'd8,  1'b1, 2'd0, 1'b0}, {8'd3,  1'b1, 2'd1, 1'b1}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_gnt = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic tx_valid, tx_ready = 1'b0, tx_sof, tx_eof, irq;
  logic [7:0] tx_data;

  tx_ring_dma dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_sof(tx_sof), .tx_eof(tx_eof), .irq(irq));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int rdy_mode = 0, gnt_mode = 0;
  logic [31:0] mem [512];
  logic [7:0] cap_d [64];
  logic cap_s [64], cap_e [64];
  int cap_n = 0, rd_n = 0;
  logic [31:0] rd_log [64];
  logic pend = 1'b0;
  logic [31:0] pend_a = '0;
  bit done = 0;

  function automatic logic [7:0] pat(input int a);
    logic [31:0] u;
    u = a;
    return (u[7:0] * 8'd7) ^ u[10:3] ^ 8'h3C;
  endfunction

  // responder and stream sink; transfers recorded for the next edge
  always @(negedge clk) begin
    cyc++;
    case (rdy_mode)
      0: tx_ready = 1'b1;
      1: tx_ready = cyc[0];
      default: tx_ready = 1'b0;
    endcase
    if (tx_valid && tx_ready && cap_n < 64) begin
      cap_d[cap_n] = tx_data; cap_s[cap_n] = tx_sof; cap_e[cap_n] = tx_eof; cap_n++;
    end
    mem_rvalid = pend;
    mem_rdata = pend ? mem[pend_a[10:2]] : 32'h0;
    pend = 1'b0;
    mem_gnt = mem_req && (gnt_mode == 0 || cyc[0]);
    if (mem_gnt) begin
      pend = 1'b1; pend_a = mem_addr;
      if (rd_n < 64) rd_log[rd_n] = mem_addr;
      rd_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] ctrlv(input bit en, input bit sus);
    return 32'(en) | (32'(sus) << 1) | (32'd1 << 11) | (32'd5 << 18);
  endfunction

  task automatic put_desc(input int s, input logic [3:0] f, input int len);
    int w;
    w = (BASE + 16 * s) >> 2;
    mem[w] = {f, 28'h0}; mem[w+1] = 32'(len); mem[w+2] = BUFB + 128 * s; mem[w+3] = 32'h0;
  endtask

  task automatic wait_ptr(input logic [31:0] p, output bit ok);
    logic [31:0] v;
    ok = 0;
    for (int i = 0; i < 3000 && !ok; i++) begin
      rd(3'd4, v);
      if (v[1:0] == 2'd2 && {v[31:4], 4'h0} == p) ok = 1;
    end
  endtask

  task automatic wait_code(input logic [1:0] c, output bit ok);
    logic [31:0] v;
    ok = 0;
    for (int i = 0; i < 3000 && !ok; i++) begin rd(3'd4, v); if (v[1:0] == c) ok = 1; end
  endtask

  task automatic wait_valid(output bit ok);
    ok = 0;
    for (int i = 0; i < 1000 && !ok; i++) begin @(negedge clk); #1 if (tx_valid) ok = 1; end
  endtask

  task automatic check_stream(input string req, input int b0, input int n0, input int b1, input int n1);
    int bad;
    bad = 0;
    chk(cap_n == n0 + n1, req, cap_n, n0 + n1);
    for (int k = 0; k < cap_n && k < n0 + n1; k++) begin
      logic [7:0] e;
      e = (k < n0) ? pat(b0 + k) : pat(b1 + k - n0);
      if (cap_d[k] !== e || cap_s[k] !== (k == 0) || cap_e[k] !== (k == n0 + n1 - 1)) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  function automatic logic [31:0] slot_a(input int s);
    return BASE + 32'(16 * s);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    bit ok;
    int s, nx, len;
    for (int w = 0; w < 512; w++)
      mem[w] = {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!tx_valid && !mem_req && !irq, "R1 outputs in reset", {tx_valid, mem_req, irq}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(3'd4, v); chk(v == 0, "R1 status after reset", v, 0);
    rd(3'd0, v); chk(v == 0, "R1 control after reset", v, 0);
    chk(!tx_valid && !mem_req && !irq, "R1 outputs after reset", {tx_valid, mem_req, irq}, 0);

    // R6 / R13: register storage
    wr(3'd2, BASE | 32'hF); rd(3'd2, v); chk(v == BASE, "R6 base low alignment", v, BASE);
    wr(3'd3, 32'hABCD0123); rd(3'd3, v); chk(v == 32'hABCD0123, "R6 base high", v, 32'hABCD0123);
    wr(3'd1, BASE | 32'hC); rd(3'd1, v); chk(v == BASE, "R6 pointer alignment", v, BASE);
    wr(3'd0, ctrlv(0, 0)); rd(3'd0, v); chk(v == ctrlv(0, 0), "R13 parity and burst readback", v, ctrlv(0, 0));
    rd(3'd4, v); chk(v[1:0] == 2'd0, "R7 disabled code", v[1:0], 0);
    wr(3'd6, 32'h1);
    wr(3'd0, ctrlv(1, 0));
    rd(3'd4, v); chk(v == (BASE | 32'h2), "R7 idle at base", v, BASE | 32'h2);

    // vector table: single-descriptor frames around the ring
    s = 0;
    for (int i = 0; i < 6; i++) begin
      len = int'(VEC[i][11:4]);
      rdy_mode = int'(VEC[i][2:1]); gnt_mode = int'(VEC[i][0]);
      put_desc(s, {1'b1, 1'b1, VEC[i][3], s == 3}, len);
      nx = (s == 3) ? 0 : s + 1;
      cap_n = 0; rd_n = 0;
      wr(3'd1, slot_a(nx));
      wait_ptr(slot_a(nx), ok);
      chk(ok, (s == 3) ? "R5 wrap to base" : "R4 walk to pointer", ok, 1);
      check_stream("R3 frame bytes", BUFB + 128 * s, len, 0, 0);
      chk(rd_log[0] == slot_a(s) && rd_log[1] == slot_a(s) + 4 && rd_log[2] == slot_a(s) + 8,
          "R2 descriptor reads", rd_log[1], slot_a(s) + 4);
      chk(rd_log[3] == BUFB + 128 * s, "R2 buffer read address", rd_log[3], BUFB + 128 * s);
      chk(irq == VEC[i][3], "R10 irq after completion", irq, VEC[i][3]);
      wr(3'd5, 32'h1); @(negedge clk);
      chk(!irq, "R10 write-one clear", irq, 0);
      s = nx;
    end
    rdy_mode = 0; gnt_mode = 0;

    // R4 / R3: one frame across two descriptors, one post
    put_desc(2, 4'b1000, 3);
    put_desc(3, 4'b0111, 6);
    cap_n = 0;
    wr(3'd1, BASE);
    wait_ptr(BASE, ok); chk(ok, "R4 multi-descriptor post", ok, 1);
    check_stream("R3 spanning frame", BUFB + 256, 3, BUFB + 384, 6);

    // R11: zero byte count
    put_desc(0, 4'b1110, 0);
    cap_n = 0; rd_n = 0;
    wr(3'd1, slot_a(1));
    wait_ptr(slot_a(1), ok);
    chk(ok && cap_n == 0, "R11 zero count no bytes", cap_n, 0);
    chk(rd_n == 3, "R11 zero count reads", rd_n, 3);
    chk(irq, "R11 zero count interrupt", irq, 1);
    wr(3'd5, 32'h1);

    // R8: suspend while streaming
    put_desc(1, 4'b1100, 6);
    put_desc(2, 4'b1100, 2);
    cap_n = 0; rdy_mode = 2;
    wr(3'd1, slot_a(3));
    wait_valid(ok);
    wr(3'd0, ctrlv(1, 1));
    rdy_mode = 0;
    wait_ptr(slot_a(2), ok);
    repeat (20) @(negedge clk);
    rd(3'd4, v);
    chk(ok && v == (slot_a(2) | 32'h2), "R8 suspended idle", v, slot_a(2) | 32'h2);
    chk(cap_n == 6, "R8 current descriptor finished", cap_n, 6);
    wr(3'd0, ctrlv(1, 0));
    wait_ptr(slot_a(3), ok);
    chk(ok && cap_n == 8, "R8 resume", cap_n, 8);

    // R9: disable during transfer
    put_desc(3, 4'b1101, 5);
    cap_n = 0; rdy_mode = 2;
    wr(3'd1, BASE);
    wait_valid(ok);
    wr(3'd0, ctrlv(0, 0));
    rd(3'd4, v); chk(v[1:0] == 2'd1, "R9 active while in flight", v[1:0], 1);
    rdy_mode = 0;
    wait_code(2'd0, ok);
    chk(ok && cap_n == 5, "R9 disabled after completion", cap_n, 5);
    wr(3'd0, ctrlv(1, 0));
    rd(3'd4, v); chk(v == (BASE | 32'h2), "R9 re-enable at base", v, BASE | 32'h2);

    // R12: missing start-of-frame
    put_desc(0, 4'b0100, 4);
    cap_n = 0;
    wr(3'd1, slot_a(1));
    wait_code(2'd3, ok);
    repeat (10) @(negedge clk);
    rd(3'd4, v);
    chk(ok && v[1:0] == 2'd3, "R12 stopped", v[1:0], 3);
    chk(cap_n == 0, "R12 no bytes", cap_n, 0);
    wr(3'd0, ctrlv(0, 0));
    rd(3'd4, v); chk(v[1:0] == 2'd0, "R12 leave by disable", v[1:0], 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule